// File: doc/BRIEF.md
# Sector Hamming Parity Generator and Single-Bit Corrector

This block computes a single-error-correcting parity code over one flash sector while the sector's bytes stream past it, one byte per accepted strobe. The code consists of two 12-bit fields. The upper field is the XOR of the bit addresses of every 1 bit in the sector. The lower field is the XOR of the complements of those same addresses. The packed 24-bit value is inverted before it leaves the block, so a fully erased sector (all bytes 0xFF) produces the code 0xFFFFFF. An erased page therefore checks clean against its erased spare area.

On the write path, software arms the block with a start pulse and streams the sector. It then pulses the read strobe to capture the code, which also clears the running parity. On the read path, software streams the sector back and presents the code that was stored with it. A check strobe then compares the two codes. The check reports one of three outcomes. A clean result means no error. A corrected result names the byte offset and bit position to flip, or says that the only fault lies in the stored code. An uncorrectable result means the error cannot be repaired. The result holds until the next start pulse.

Top module: `hamming_sector_ecc`

## Requirements
- R1: After reset, `sec_done` is 0, `chk_status` is 2'b00, `ecc_code` is 0, and `fix_byte`, `fix_bit` and `fix_flip` are 0.
- R2: A `sec_start` pulse clears the running parity and the accepted-byte count. It arms accumulation, clears `sec_done`, and returns `chk_status` and the location outputs to 0. It takes priority over every other strobe in the same cycle.
- R3: Each accepted byte at sector offset k adds, for every set bit b, the 12-bit address a = {k[8:0], b[2:0]}. The address is XORed into the upper field H and its complement ~a into the lower field L. The code presented is ~{H, L}. `ecc_code[7:0]` is the first byte to store, then [15:8], then [23:16].
- R4: A sector of SECTOR_BYTES bytes of 0xFF yields the code 24'hFFFFFF.
- R5: `sec_done` rises after exactly SECTOR_BYTES accepted bytes, and accumulation then stops. Bytes strobed while not armed change nothing.
- R6: A `code_rd` pulse copies the current code to `ecc_code`, clears the running parity and count, and disarms. A second read with no bytes in between returns 24'hFFFFFF.
- R7: On `code_chk`, the difference D = `code_stored` XOR current code is formed. If D is zero, `chk_status` becomes 2'b00.
- R8: If D[23:12] XOR D[11:0] equals 12'hFFF and D[23:15] < SECTOR_BYTES, the check reports a data error that can be repaired. `chk_status` becomes 2'b01, `fix_flip` becomes 1, `fix_byte` becomes D[23:15] and `fix_bit` becomes D[14:12].
- R9: If D[23:12] XOR D[11:0] equals 12'hFFF but D[23:15] >= SECTOR_BYTES, `chk_status` becomes 2'b10.
- R10: If D has exactly one bit set, the fault lies in the stored code alone. `chk_status` becomes 2'b01, with `fix_flip` 0 and location 0.
- R11: Any other nonzero D gives `chk_status` 2'b10, `fix_flip` 0 and location 0. This includes two data-bit errors.
- R12: `chk_status` uses only 2'b00 clean, 2'b01 corrected and 2'b10 uncorrectable. It changes only on `code_chk`, `sec_start` or reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sec_start | input | 1 | Clear and arm accumulation; clear result |
| byte_vld | input | 1 | Data byte strobe |
| byte_in | input | 8 | Data byte |
| code_rd | input | 1 | Capture code to `ecc_code`, clear parity, disarm |
| code_chk | input | 1 | Compare `code_stored` with current code |
| code_stored | input | 24 | Code read back from the spare area |
| ecc_code | output | 24 | Captured inverted code, byte 0 in bits 7:0 |
| sec_done | output | 1 | SECTOR_BYTES bytes accepted |
| chk_status | output | 2 | 00 clean, 01 corrected, 10 uncorrectable |
| fix_byte | output | 9 | Byte offset to flip |
| fix_bit | output | 3 | Bit position to flip |
| fix_flip | output | 1 | A data bit must be flipped |

## Verification
The bound checker watches several behaviours on every cycle:
- the status never takes the unused encoding;
- a start pulse always leaves a clean, not-done result;
- the status holds while no start or check arrives;
- a flip request appears only with a corrected status;
- `sec_done` rises exactly when an independent count of accepted bytes reaches the sector size.

The values of the parity code cannot be observed cycle by cycle. The same holds for the three decoding outcomes for particular error patterns, the out-of-range location case, and the clearing effect of a code read. The bench scenarios show these by comparing against a bit-level model. That model flips chosen data bits and code bits, and feeds bytes while the block is disarmed.

// File: rtl/hamming_ecc_pkg.sv
package hamming_ecc_pkg;

    localparam int HALF_W  = 12;
    localparam int CODE_W  = 2 * HALF_W;
    localparam int BIDX_W  = 9;
    localparam int BITI_W  = 3;
    localparam int BYTE_W  = 8;

    typedef enum logic [1:0] {
        ST_CLEAN = 2'b00,
        ST_FIXED = 2'b01,
        ST_BAD   = 2'b10
    } chk_status_t;

    typedef struct packed {
        logic [HALF_W-1:0] hi;
        logic [HALF_W-1:0] lo;
    } parity_pair_t;

    typedef struct packed {
        chk_status_t       status;
        logic              flip;
        logic [BIDX_W-1:0] byte_idx;
        logic [BITI_W-1:0] bit_idx;
    } fix_result_t;

    // Parity contribution of one byte at a given sector offset.
    function automatic parity_pair_t byte_contrib(input logic [BIDX_W-1:0] idx,
                                                  input logic [BYTE_W-1:0] d);
        parity_pair_t      r;
        logic              p;
        logic [BITI_W-1:0] xb;
        p  = ^d;
        xb = '0;
        for (int b = 0; b < BYTE_W; b++) begin
            if (d[b]) xb = xb ^ BITI_W'(b);
        end
        r.hi = {(p ? idx : {BIDX_W{1'b0}}), xb};
        r.lo = {(p ? ~idx : {BIDX_W{1'b0}}), xb ^ {BITI_W{p}}};
        return r;
    endfunction

    // Presented code: packed fields, inverted.
    function automatic logic [CODE_W-1:0] pack_code(input parity_pair_t acc);
        return ~{acc.hi, acc.lo};
    endfunction

    // Classify the difference between stored and computed code.
    function automatic fix_result_t classify(input logic [CODE_W-1:0] diff,
                                             input int unsigned        nbytes);
        fix_result_t r;
        r = '{status: ST_CLEAN, flip: 1'b0, byte_idx: '0, bit_idx: '0};
        if (diff != '0) begin
            if ((diff[CODE_W-1:HALF_W] ^ diff[HALF_W-1:0]) == {HALF_W{1'b1}}) begin
                if (32'(diff[CODE_W-1:CODE_W-BIDX_W]) < nbytes) begin
                    r.status   = ST_FIXED;
                    r.flip     = 1'b1;
                    r.byte_idx = diff[CODE_W-1:CODE_W-BIDX_W];
                    r.bit_idx  = diff[HALF_W+BITI_W-1:HALF_W];
                end else begin
                    r.status = ST_BAD;
                end
            end else if ($onehot(diff)) begin
                r.status = ST_FIXED;
            end else begin
                r.status = ST_BAD;
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/ecc_accum.sv
module ecc_accum
    import hamming_ecc_pkg::*;
#(
    parameter int SECTOR_BYTES = 512
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clr_arm,
    input  logic               clr_idle,
    input  logic               vld,
    input  logic [BYTE_W-1:0]  din,
    output parity_pair_t       acc,
    output logic               done
);
    localparam int CNT_W = $clog2(SECTOR_BYTES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(SECTOR_BYTES - 1);

    logic [CNT_W-1:0] cnt;
    logic             armed;
    logic             take;
    parity_pair_t     contrib;

    assign take    = vld && armed;
    assign contrib = byte_contrib(BIDX_W'(cnt), din);

    always_ff @(posedge clk) begin
        if (rst) begin
            acc   <= '0;
            cnt   <= '0;
            armed <= 1'b0;
            done  <= 1'b0;
        end else if (clr_arm) begin
            acc   <= '0;
            cnt   <= '0;
            armed <= 1'b1;
            done  <= 1'b0;
        end else if (clr_idle) begin
            acc   <= '0;
            cnt   <= '0;
            armed <= 1'b0;
        end else if (take) begin
            acc <= acc ^ contrib;
            cnt <= cnt + 1'b1;
            if (cnt == LAST) begin
                armed <= 1'b0;
                done  <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/ecc_decode.sv
module ecc_decode
    import hamming_ecc_pkg::*;
#(
    parameter int SECTOR_BYTES = 512
) (
    input  logic [CODE_W-1:0] stored,
    input  logic [CODE_W-1:0] computed,
    output fix_result_t       res
);
    logic [CODE_W-1:0] diff;
    assign diff = stored ^ computed;
    assign res  = classify(diff, SECTOR_BYTES);
endmodule

// File: rtl/hamming_sector_ecc.sv
module hamming_sector_ecc
    import hamming_ecc_pkg::*;
#(
    parameter int SECTOR_BYTES = 512
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        sec_start,
    input  logic        byte_vld,
    input  logic [7:0]  byte_in,
    input  logic        code_rd,
    input  logic        code_chk,
    input  logic [23:0] code_stored,
    output logic [23:0] ecc_code,
    output logic        sec_done,
    output logic [1:0]  chk_status,
    output logic [8:0]  fix_byte,
    output logic [2:0]  fix_bit,
    output logic        fix_flip
);
    parity_pair_t      acc;
    logic [CODE_W-1:0] cur_code;
    fix_result_t       dec;
    fix_result_t       res_q;
    logic [CODE_W-1:0] code_q;

    ecc_accum #(.SECTOR_BYTES(SECTOR_BYTES)) u_accum (
        .clk      (clk),
        .rst      (rst),
        .clr_arm  (sec_start),
        .clr_idle (code_rd),
        .vld      (byte_vld),
        .din      (byte_in),
        .acc      (acc),
        .done     (sec_done)
    );

    assign cur_code = pack_code(acc);

    ecc_decode #(.SECTOR_BYTES(SECTOR_BYTES)) u_decode (
        .stored   (code_stored),
        .computed (cur_code),
        .res      (dec)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q  <= '{status: ST_CLEAN, flip: 1'b0, byte_idx: '0, bit_idx: '0};
            code_q <= '0;
        end else if (sec_start) begin
            res_q  <= '{status: ST_CLEAN, flip: 1'b0, byte_idx: '0, bit_idx: '0};
        end else begin
            if (code_chk) res_q  <= dec;
            if (code_rd)  code_q <= cur_code;
        end
    end

    assign ecc_code   = code_q;
    assign chk_status = res_q.status;
    assign fix_byte   = res_q.byte_idx;
    assign fix_bit    = res_q.bit_idx;
    assign fix_flip   = res_q.flip;
endmodule

// File: rtl/hamming_sector_ecc_chk.sv
module hamming_sector_ecc_chk #(
    parameter int SECTOR_BYTES = 512
) (
    input logic        clk,
    input logic        rst,
    input logic        sec_start,
    input logic        byte_vld,
    input logic        code_rd,
    input logic        code_chk,
    input logic        sec_done,
    input logic [1:0]  chk_status,
    input logic [8:0]  fix_byte,
    input logic [2:0]  fix_bit,
    input logic        fix_flip
);
    localparam int CNT_W = $clog2(SECTOR_BYTES + 1);

    logic [CNT_W-1:0] seen;
    logic             arm_m;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen  <= '0;
            arm_m <= 1'b0;
        end else if (sec_start) begin
            seen  <= '0;
            arm_m <= 1'b1;
        end else if (code_rd) begin
            seen  <= '0;
            arm_m <= 1'b0;
        end else if (byte_vld && arm_m) begin
            seen <= seen + 1'b1;
            if (seen == CNT_W'(SECTOR_BYTES - 1)) arm_m <= 1'b0;
        end
    end

    a_r12_status_legal: assert property (@(posedge clk) disable iff (rst)
        chk_status != 2'b11);

    a_r2_start_clears: assert property (@(posedge clk) disable iff (rst)
        sec_start |=> (chk_status == 2'b00 && !sec_done && !fix_flip));

    a_r12_status_hold: assert property (@(posedge clk) disable iff (rst)
        (!sec_start && !code_chk) |=> $stable(chk_status));

    a_r8_flip_needs_fixed: assert property (@(posedge clk) disable iff (rst)
        fix_flip |-> chk_status == 2'b01);

    a_r11_bad_no_location: assert property (@(posedge clk) disable iff (rst)
        (chk_status == 2'b10) |-> (fix_byte == 9'd0 && fix_bit == 3'd0 && !fix_flip));

    a_r5_done_count: assert property (@(posedge clk) disable iff (rst)
        $rose(sec_done) |-> (seen == CNT_W'(SECTOR_BYTES)));
endmodule

bind hamming_sector_ecc hamming_sector_ecc_chk #(.SECTOR_BYTES(SECTOR_BYTES)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .sec_start  (sec_start),
    .byte_vld   (byte_vld),
    .code_rd    (code_rd),
    .code_chk   (code_chk),
    .sec_done   (sec_done),
    .chk_status (chk_status),
    .fix_byte   (fix_byte),
    .fix_bit    (fix_bit),
    .fix_flip   (fix_flip)
);

// File: tb/test_hamming_sector_ecc.sv
module test_hamming_sector_ecc;
    localparam int SEC = 256;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sec_start = 1'b0;
    logic        byte_vld = 1'b0;
    logic [7:0]  byte_in = 8'd0;
    logic        code_rd = 1'b0;
    logic        code_chk = 1'b0;
    logic [23:0] code_stored = 24'd0;
    logic [23:0] ecc_code;
    logic        sec_done;
    logic [1:0]  chk_status;
    logic [8:0]  fix_byte;
    logic [2:0]  fix_bit;
    logic        fix_flip;

    int checks = 0;
    int fails  = 0;
    int seed   = 32'h1a2b3c;
    logic [7:0] mem [0:SEC-1];

    always #10 clk = ~clk;

    hamming_sector_ecc #(.SECTOR_BYTES(SEC)) i_hamming_sector_ecc (
        .clk(clk), .rst(rst), .sec_start(sec_start), .byte_vld(byte_vld),
        .byte_in(byte_in), .code_rd(code_rd), .code_chk(code_chk),
        .code_stored(code_stored), .ecc_code(ecc_code), .sec_done(sec_done),
        .chk_status(chk_status), .fix_byte(fix_byte), .fix_bit(fix_bit),
        .fix_flip(fix_flip)
    );

    task automatic expect_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Bit-level reference: walk every bit address.
    function automatic logic [23:0] model_code();
        logic [11:0] h = 12'd0;
        logic [11:0] l = 12'd0;
        for (int k = 0; k < SEC; k++)
            for (int b = 0; b < 8; b++)
                if (mem[k][b]) begin
                    h = h ^ 12'(k * 8 + b);
                    l = l ^ ~12'(k * 8 + b);
                end
        return ~{h, l};
    endfunction

    task automatic pulse_start();
        @(negedge clk) sec_start = 1'b1;
        @(negedge clk) sec_start = 1'b0;
    endtask
    task automatic pulse_rd();
        @(negedge clk) code_rd = 1'b1;
        @(negedge clk) code_rd = 1'b0;
    endtask
    task automatic pulse_chk(input logic [23:0] st);
        @(negedge clk) begin code_chk = 1'b1; code_stored = st; end
        @(negedge clk) code_chk = 1'b0;
    endtask
    task automatic feed(input int from, input int upto);
        for (int k = from; k < upto; k++) begin
            @(negedge clk) begin byte_vld = 1'b1; byte_in = mem[k]; end
        end
        @(negedge clk) byte_vld = 1'b0;
    endtask
    task automatic fill_random();
        for (int k = 0; k < SEC; k++) mem[k] = 8'($urandom);
    endtask
    task automatic expect_result(input string req, input logic [1:0] st,
                                 input logic fl, input int by, input int bi);
        expect_eq({req, " status"}, 32'(chk_status), 32'(st));
        expect_eq({req, " flip"},   32'(fix_flip),   32'(fl));
        expect_eq({req, " byte"},   32'(fix_byte),   32'(by));
        expect_eq({req, " bit"},    32'(fix_bit),    32'(bi));
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : main
        logic [23:0] good;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        expect_result("R1", 2'b00, 1'b0, 0, 0);
        expect_eq("R1 done", 32'(sec_done), 0);
        expect_eq("R1 code", 32'(ecc_code), 0);

        // R4 erased sector
        for (int k = 0; k < SEC; k++) mem[k] = 8'hFF;
        pulse_start();
        feed(0, SEC);
        pulse_chk(24'hFFFFFF);
        expect_result("R4 R7 erased clean", 2'b00, 1'b0, 0, 0);
        pulse_rd();
        expect_eq("R4 erased code", 32'(ecc_code), 32'h00FFFFFF);

        // R3 R7 random sectors, R6 capture
        for (int t = 0; t < 6; t++) begin
            fill_random();
            if (t == 0) begin
                for (int k = 0; k < SEC; k++) mem[k] = 8'h00;
                mem[0] = 8'h01;
                mem[SEC-1] = 8'h80;
            end
            good = model_code();
            pulse_start();
            // R5 done exactly at SEC
            feed(0, SEC - 1);
            expect_eq("R5 not done early", 32'(sec_done), 0);
            feed(SEC - 1, SEC);
            expect_eq("R5 done", 32'(sec_done), 1);
            pulse_chk(good);
            expect_result("R7 clean", 2'b00, 1'b0, 0, 0);
            // R5 bytes after done ignored
            feed(0, 7);
            pulse_rd();
            expect_eq("R3 R6 code", 32'(ecc_code), 32'(good));
            expect_eq("R3 byte0 order", 32'(ecc_code[7:0]), 32'(good[7:0]));
        end

        // R6 read clears, bytes while disarmed ignored (R5)
        feed(0, 20);
        pulse_rd();
        expect_eq("R6 R5 cleared code", 32'(ecc_code), 32'h00FFFFFF);

        // R8 single data bit errors, corners and random
        for (int t = 0; t < 8; t++) begin
            int k;
            int b;
            fill_random();
            good = model_code();
            k = (t == 0) ? 0 : (t == 1) ? SEC - 1 : int'($urandom % SEC);
            b = (t == 0) ? 0 : (t == 1) ? 7 : int'($urandom % 8);
            mem[k][b] = ~mem[k][b];
            pulse_start();
            feed(0, SEC);
            pulse_chk(good);
            expect_result("R8 data bit", 2'b01, 1'b1, k, b);
            // R12 held until start
            repeat (3) @(negedge clk);
            expect_eq("R12 held", 32'(chk_status), 1);
            pulse_start();
            expect_result("R2 start clears", 2'b00, 1'b0, 0, 0);
        end

        // R10 single code bit, R11 double data error, R9 out of range
        fill_random();
        good = model_code();
        pulse_start();
        feed(0, SEC);
        for (int j = 0; j < 24; j += 5) begin
            pulse_chk(good ^ (24'd1 << j));
            expect_result("R10 code bit", 2'b01, 1'b0, 0, 0);
        end
        begin
            logic [11:0] a;
            a = 12'(300 * 8 + 2);
            pulse_chk(good ^ {a, ~a});
            expect_result("R9 out of range", 2'b10, 1'b0, 0, 0);
            a = 12'(200 * 8 + 6);
            pulse_chk(good ^ {a, ~a});
            expect_result("R8 in range", 2'b01, 1'b1, 200, 6);
        end
        pulse_chk(good ^ 24'h000011);
        expect_result("R11 two code bits", 2'b10, 1'b0, 0, 0);
        mem[3][1] = ~mem[3][1];
        mem[90][6] = ~mem[90][6];
        pulse_start();
        feed(0, SEC);
        pulse_chk(good);
        expect_result("R11 two data bits", 2'b10, 1'b0, 0, 0);
        expect_eq("R12 legal", 32'(chk_status != 2'b11), 1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule